// File: doc/BRIEF.md
# Length-Addressed Serial Control Register Receiver

This block is a slave receiver for a three-line serial configuration port made of an active-low enable, a serial clock and a data line. A host frames each command by holding enable low. It shifts bits on the falling edges of the serial clock, most significant bit first, and then releases enable. The block picks the target register from two things: how many bits arrived (8, 16 or 24) and a 2-bit address held in the top two bits of the final byte. There are four 8-bit, four 16-bit and three 24-bit registers. Their payload bits together make up one flat 146-bit control vector.

The serial lines are oversampled by the system clock through two-flop synchronizers, and their edges are found in the system clock domain. A frame with an unsupported length, or with an address that is unused at its length, is dropped and no state changes. An accepted frame updates its register field in one cycle and raises a one-cycle write strobe.

Top module: `serial_cfg_rx`

## Requirements
- R1: After reset, `ctrl_bits` is all zero and `wr_stb` is low.
- R2: Data is captured only on falling edges of `cfg_clk` while `cfg_en_n` is low. The first bit captured is the most significant bit of the frame.
- R3: A command of exactly 8 bits uses frame bits [7:6] as address a (0..3). It writes frame bits [5:0] to `ctrl_bits[6a+5:6a]`.
- R4: A command of exactly 16 bits uses frame bits [7:6] as address a (0..3). It writes {frame[5:0], frame[15:8]} to `ctrl_bits[24+14a+13:24+14a]`.
- R5: A command of exactly 24 bits with address a = frame[7:6] in 0..2 writes {frame[5:0], frame[15:8], frame[23:16]} to `ctrl_bits[80+22a+21:80+22a]`.
- R6: A command whose bit count is not 8, 16 or 24 changes no bit of `ctrl_bits` and gives no strobe. This includes zero bits and counts above 24, however many bits arrive.
- R7: A 24-bit command with address 3 is discarded. No bit changes and no strobe is given.
- R8: A write takes effect only after `cfg_en_n` returns high. All bits of the addressed field change in the same cycle, no other field changes, and `wr_stb` is high for exactly that one cycle.
- R9: Clock falling edges while `cfg_en_n` is high are ignored. They neither start a command nor add to the next one.
- R10: Each falling edge of `cfg_en_n` starts a new count and clears any bits left over from an earlier command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en_n | input | 1 | Serial enable, low frames a command |
| cfg_clk | input | 1 | Serial clock, data taken on falling edge |
| cfg_dat | input | 1 | Serial data, MSB first |
| ctrl_bits | output | 146 | Flat control vector of all registers |
| wr_stb | output | 1 | One-cycle pulse when a register is written |

## Verification
The hardest case to reach from the ports is a long command whose bit count would wrap a narrow counter back onto a legal length. A 40-bit frame aliases to 8 in a 5-bit counter. The bench sends such frames alongside 0, 7, 9, 23 and 32-bit frames and the unused 24-bit address, and confirms that the vector stays untouched. It also toggles the serial clock with enable high, and it follows a 23-bit frame with an 8-bit one. This shows that stray edges and leftover bits never reach a later command.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 2;
    localparam int N_CLASS    = 3;
    localparam int REGS_FULL  = 4;
    localparam int REGS_LAST  = 3;
    localparam int SUB_W      = BYTE_W - ADDR_W;
    localparam int SHIFT_W    = N_CLASS * BYTE_W;
    localparam int PAY_W      = SHIFT_W - ADDR_W;
    localparam int CNT_W      = $clog2(SHIFT_W + 1);

    function automatic int cls_regs(input int c);
        return (c == N_CLASS - 1) ? REGS_LAST : REGS_FULL;
    endfunction

    function automatic int cls_width(input int c);
        return (c + 1) * BYTE_W - ADDR_W;
    endfunction

    function automatic int cls_base(input int c, input int a);
        int b;
        b = 0;
        for (int k = 0; k < c; k++) b += cls_regs(k) * cls_width(k);
        return b + a * cls_width(c);
    endfunction

    localparam int CTRL_W = cls_base(N_CLASS, 0);
    localparam int BASE_W = $clog2(CTRL_W);

    typedef enum logic [1:0] {CLS_8, CLS_16, CLS_24, CLS_NONE} frame_cls_e;

    typedef struct packed {
        logic [SHIFT_W-1:0] bits;
        logic [CNT_W-1:0]   count;
    } frame_t;

    typedef struct packed {
        logic              en;
        logic [BASE_W-1:0] base;
        logic [PAY_W-1:0]  data;
        logic [PAY_W-1:0]  mask;
    } write_t;

    function automatic frame_cls_e classify(input logic [CNT_W-1:0] n);
        frame_cls_e r;
        r = CLS_NONE;
        for (int k = 0; k < N_CLASS; k++)
            if (n == CNT_W'((k + 1) * BYTE_W)) r = frame_cls_e'(k);
        return r;
    endfunction

    function automatic write_t decode(input frame_t f);
        write_t             w;
        frame_cls_e         cls;
        int                 c;
        int                 a;
        w   = '0;
        cls = classify(f.count);
        a   = int'(f.bits[BYTE_W-1 -: ADDR_W]);
        if (cls != CLS_NONE) begin
            c = int'(cls);
            if (a < cls_regs(c)) begin
                w.en   = 1'b1;
                w.base = BASE_W'(cls_base(c, a));
                w.mask = PAY_W'((64'd1 << cls_width(c)) - 64'd1);
                for (int k = 0; k < N_CLASS - 1; k++)
                    if (k < c)
                        w.data[k*BYTE_W +: BYTE_W] = f.bits[(c-k)*BYTE_W + BYTE_W - 1 -: BYTE_W];
                w.data[c*BYTE_W +: SUB_W] = f.bits[SUB_W-1:0];
            end
        end
        return w;
    endfunction

endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/cfg3w_shifter.sv
module cfg3w_shifter
    import cfg3w_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en_n_s,
    input  logic   sclk_s,
    input  logic   sdat_s,
    output frame_t frame,
    output logic   frame_vld
);
    logic               en_d;
    logic               sclk_d;
    logic [SHIFT_W-1:0] sh;
    logic [CNT_W-1:0]   cnt;
    logic               en_fall, en_rise, bit_edge;

    assign en_fall  = en_d & ~en_n_s;
    assign en_rise  = ~en_d & en_n_s;
    assign bit_edge = ~en_n_s & sclk_d & ~sclk_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d      <= 1'b1;
            sclk_d    <= 1'b0;
            sh        <= '0;
            cnt       <= '0;
            frame     <= '0;
            frame_vld <= 1'b0;
        end else begin
            en_d      <= en_n_s;
            sclk_d    <= sclk_s;
            frame_vld <= 1'b0;
            if (en_fall) begin
                sh  <= '0;
                cnt <= '0;
            end else if (bit_edge) begin
                sh <= {sh[SHIFT_W-2:0], sdat_s};
                if (cnt != '1) cnt <= cnt + 1'b1;
            end
            if (en_rise) begin
                frame_vld <= 1'b1;
                frame     <= '{bits: sh, count: cnt};
            end
        end
    end
endmodule

// File: rtl/cfg3w_bank.sv
module cfg3w_bank
    import cfg3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  frame_t            frame,
    input  logic              frame_vld,
    output logic [CTRL_W-1:0] ctrl,
    output logic              stb
);
    write_t            w;
    logic [CTRL_W-1:0] mask_ext;
    logic [CTRL_W-1:0] data_ext;

    always_comb begin
        w        = decode(frame);
        mask_ext = CTRL_W'(w.mask) << w.base;
        data_ext = CTRL_W'(w.data) << w.base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            stb  <= 1'b0;
        end else begin
            stb <= 1'b0;
            if (frame_vld && w.en) begin
                ctrl <= (ctrl & ~mask_ext) | (data_ext & mask_ext);
                stb  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_cfg_rx.sv
module serial_cfg_rx
    import cfg3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en_n,
    input  logic              cfg_clk,
    input  logic              cfg_dat,
    output logic [CTRL_W-1:0] ctrl_bits,
    output logic              wr_stb
);
    logic [2:0] pins_s;
    frame_t     frame;
    logic       frame_vld;

    cfg3w_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cfg_en_n, cfg_clk, cfg_dat}),
        .q   (pins_s)
    );

    cfg3w_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .en_n_s    (pins_s[2]),
        .sclk_s    (pins_s[1]),
        .sdat_s    (pins_s[0]),
        .frame     (frame),
        .frame_vld (frame_vld)
    );

    cfg3w_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .frame     (frame),
        .frame_vld (frame_vld),
        .ctrl      (ctrl_bits),
        .stb       (wr_stb)
    );
endmodule

// File: rtl/cfg3w_chk.sv
module cfg3w_chk
    import cfg3w_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_en_n,
    input logic [CTRL_W-1:0] ctrl_bits,
    input logic              wr_stb
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_bits == '0 && !wr_stb));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R8
    change_needs_stb_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_bits) |-> wr_stb);

    // R8
    enable_released_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> cfg_en_n);

    // R8
    one_field_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $countones(ctrl_bits ^ $past(ctrl_bits)) <= PAY_W);
endmodule

bind serial_cfg_rx cfg3w_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_en_n  (cfg_en_n),
    .ctrl_bits (ctrl_bits),
    .wr_stb    (wr_stb)
);

// File: tb/sim_serial_cfg_rx.sv
module sim_serial_cfg_rx;
    localparam int CW = 146;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_en_n = 1'b1;
    logic          cfg_clk = 1'b0;
    logic          cfg_dat = 1'b0;
    logic [CW-1:0] ctrl_bits;
    logic          wr_stb;

    always #10 clk = ~clk;

    serial_cfg_rx u0 (
        .clk(clk), .rst(rst), .cfg_en_n(cfg_en_n), .cfg_clk(cfg_clk),
        .cfg_dat(cfg_dat), .ctrl_bits(ctrl_bits), .wr_stb(wr_stb)
    );

    typedef struct {
        logic [CW-1:0] v;
        string         tag;
    } exp_t;

    exp_t          q[$];
    logic [CW-1:0] shadow = '0;
    int            checks = 0;
    int            errors = 0;
    int            stb_seen = 0;
    int            stb_want = 0;
    bit            done = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && wr_stb) begin
            stb_seen++;
            if (q.size() == 0) begin
                check(0, "R6", "unexpected strobe", ctrl_bits, shadow);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(ctrl_bits == e.v, e.tag, "value at strobe", ctrl_bits, e.v);
            end
        end
    end

    // bench-side model of the register layout
    task automatic model(input int n, input logic [47:0] v, input string tag);
        int            base, w;
        logic [21:0]   pay;
        logic [1:0]    a;
        exp_t          e;
        a = v[7:6];
        case (n)
            8:  begin base = 6 * a;       w = 6;  pay = {16'd0, v[5:0]}; end
            16: begin base = 24 + 14 * a; w = 14; pay = {8'd0, v[5:0], v[15:8]}; end
            24: begin base = 80 + 22 * a; w = 22; pay = {v[5:0], v[15:8], v[23:16]}; end
            default: begin base = -1; w = 0; pay = '0; end
        endcase
        if (n == 24 && a == 2'd3) base = -1;
        if (base >= 0) begin
            for (int j = 0; j < w; j++) shadow[base + j] = pay[j];
            e.v = shadow;
            e.tag = tag;
            q.push_back(e);
            stb_want++;
        end
    endtask

    task automatic send(input int n, input logic [47:0] v, input string tag);
        @(negedge clk);
        cfg_en_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            cfg_dat = v[i];
            repeat (5) @(negedge clk);
            cfg_clk = 1'b1;
            repeat (8) @(negedge clk);
            cfg_clk = 1'b0;
            repeat (5) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        // R8: nothing written while enable is still low
        check(ctrl_bits == shadow, "R8", "changed before enable rise", ctrl_bits, shadow);
        cfg_en_n = 1'b1;
        model(n, v, tag);
        repeat (30) @(negedge clk);
        check(ctrl_bits == shadow, tag, "vector after frame", ctrl_bits, shadow);
        check(stb_seen == stb_want, tag, "strobe count",
              CW'(stb_seen), CW'(stb_want));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ctrl_bits == '0, "R1", "reset vector", ctrl_bits, '0);
        check(wr_stb == 1'b0, "R1", "reset strobe", CW'(wr_stb), '0);

        // R3 all four 8-bit registers
        send(8, 48'h2A, "R3");
        send(8, 48'h55, "R3");
        send(8, 48'hBF, "R3");
        send(8, 48'hE1, "R3");
        // R2 MSB-first ordering: asymmetric pattern
        send(8, 48'h01, "R2");
        // R4 16-bit registers
        send(16, 48'h5A_33, "R4");
        send(16, 48'hC3_7E, "R4");
        send(16, 48'hFF_BF, "R4");
        send(16, 48'h81_C0, "R4");
        // R5 24-bit registers 0..2
        send(24, 48'h12_34_3F, "R5");
        send(24, 48'hA5_F0_55, "R5");
        send(24, 48'hFF_FF_BF, "R5");
        send(24, 48'h01_80_80, "R5");
        // R6 bad lengths
        send(0, 48'h0, "R6");
        send(7, 48'h7F, "R6");
        send(9, 48'h1FF, "R6");
        send(23, 48'h7F_FF_FF, "R6");
        send(25, 48'h1_FF_FF_FF, "R6");
        send(32, 48'hFFFF_FFFF, "R6");
        send(40, 48'hFF_FFFF_FF3F, "R6");
        // R7 unused 24-bit address
        send(24, 48'hFF_FF_FF, "R7");
        send(24, 48'h00_00_C0, "R7");
        // R9 clock edges with enable high
        for (int i = 0; i < 5; i++) begin
            cfg_dat = 1'b1;
            repeat (5) @(negedge clk);
            cfg_clk = 1'b1;
            repeat (8) @(negedge clk);
            cfg_clk = 1'b0;
            repeat (5) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        check(ctrl_bits == shadow, "R9", "idle clocks changed vector", ctrl_bits, shadow);
        check(stb_seen == stb_want, "R9", "idle clocks strobe", CW'(stb_seen), CW'(stb_want));
        send(8, 48'h4C, "R9");
        // R10 leftover bits from a rejected frame do not leak
        send(23, 48'h55_AA_FF, "R10");
        send(8, 48'h80, "R10");
        send(16, 48'h00_00, "R10");

        check(q.size() == 0, "R8", "pending expected writes", CW'(q.size()), '0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule